// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block behaves as the slave side of a three-wire serial memory: a select line, a serial clock and a serial data input, plus a serial data output with its own output enable. All four serial lines are sampled on the system clock. A serial clock edge is recognised as a low-to-high change between two samples. Behind the serial port sits an array of `2**ADDR_W` words of `DATA_W` bits. After reset every word holds all ones and writes are locked.

A transaction starts with a 1 bit while selected, followed by a 2-bit opcode and `ADDR_W` address bits. Opcode `10` reads and opcode `01` writes one word. Opcode `11` clears one word to all ones. Opcode `00` is qualified by the two most significant address bits: `11` unlocks writes, `00` locks them, `10` clears the whole array and `01` fills the whole array with one data word.

Reads stream out and continue through ascending addresses for as long as the clock runs. Program commands are held until the select line drops. They then run a self-timed cycle of `PROG_CYCLES` system clocks, and the controller can poll that cycle on the data output.

Top module: `serial_eeprom`

## Requirements
- R1: A command is recognised only while `chipSel` is high, on serial clock rising edges. Leading 0 bits are skipped, and the first 1 bit is the start bit. It is followed by a 2-bit opcode and `ADDR_W` address bits, all sent MSB first.
- R2: For a read (opcode `10`), `serOutEn` goes high after the last address bit and `serOut` shows one dummy 0. Each following serial clock rising edge then presents the addressed word, MSB first.
- R3: If clocking continues after bit 0 of a word, the word at the next address follows immediately with no dummy bit. The address after the highest one is 0.
- R4: A write (opcode `01`) takes `DATA_W` data bits MSB first after the address. Once its program cycle ends, the addressed word equals the data, whatever it held before.
- R5: A word clear (opcode `11`) sets one word to all ones. Array clear (opcode `00`, top address bits `10`) sets every word to all ones. Array fill (opcode `00`, top address bits `01`, followed by a data word) sets every word to that data.
- R6: After reset, writes are locked. Unlock is opcode `00` with top address bits `11`, and lock is opcode `00` with top address bits `00`. Both take effect whatever the level of `progEn`. A program command received while locked changes no word and starts no program cycle.
- R7: A program command changes memory only if `progEn` is 1 when its last bit is received.
- R8: A complete program command starts its cycle when `chipSel` falls. If `chipSel` falls before the command is complete, the command is dropped with no change and no busy status.
- R9: The program cycle lasts `PROG_CYCLES` system clocks. While `chipSel` is high, `serOutEn` is 1 and `serOut` shows 0 during the cycle and 1 after it. This status stays until the next start bit.
- R10: `serOutEn` is 0 whenever `chipSel` is low, and 0 while selected with no read or status pending.
- R11: A start bit clocked while a program cycle is running is ignored.
- R12: After reset every word reads as all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chipSel | input | 1 | Serial select, active high |
| serClk | input | 1 | Serial clock, sampled by `clk` |
| serIn | input | 1 | Serial data input |
| progEn | input | 1 | Program permission for write, clear and fill |
| serOut | output | 1 | Serial data output (read data or ready/busy status) |
| serOutEn | output | 1 | Output enable for `serOut` (0 means high impedance) |

## Verification
The bench builds the block with `ADDR_W` = 3, which gives eight words and a 5-bit command. With so few words, a sequential read crosses from the highest address to 0 within a few dozen serial clocks, and array fill and array clear can be checked at addresses spread across the whole array. `PROG_CYCLES` is set to 20. This makes the busy window short enough to wait out many times, yet long enough to reselect the block, see busy, and clock an ignored start bit inside it. `DATA_W` stays at 16.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_CLEAR = 2'b11;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b01;
  localparam logic [1:0] EXT_WIPE   = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

  typedef enum logic [1:0] {
    PK_WORD,
    PK_CLEAR,
    PK_FILL,
    PK_WIPE
  } progKind_e;

  typedef struct packed {
    logic      cmdShift;
    logic      dataShift;
    logic      rdLoad;
    logic      rdShift;
    logic      rdWordEnd;
    logic      progCommit;
    progKind_e kind;
  } dpStrobe_t;

endpackage

// File: rtl/seeprom_datapath.sv
module seeprom_datapath
  import seeprom_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  dpStrobe_t         strobe,
  output logic [1:0]        cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              outBit
);

  localparam int WORDS   = 1 << ADDR_W;
  localparam int CMD_W   = ADDR_W + 2;

  logic [CMD_W-1:0]  cmdReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] shReg;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] rdNext;
  logic [DATA_W-1:0] mem [WORDS];

  assign cmdOp   = cmdReg[CMD_W-1 -: 2];
  assign cmdAddr = cmdReg[ADDR_W-1:0];
  assign rdNext  = rdAddr + 1'b1;

  // command and data shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.cmdShift)  cmdReg  <= {cmdReg[CMD_W-2:0], serIn};
      if (strobe.dataShift) dataReg <= {dataReg[DATA_W-2:0], serIn};
    end
  end

  // read streaming: dummy zero, then words MSB first with address rollover
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      rdAddr <= '0;
      outBit <= 1'b0;
    end else if (strobe.rdLoad) begin
      shReg  <= mem[cmdAddr];
      rdAddr <= cmdAddr;
      outBit <= 1'b0;
    end else if (strobe.rdShift) begin
      outBit <= shReg[DATA_W-1];
      if (strobe.rdWordEnd) begin
        shReg  <= mem[rdNext];
        rdAddr <= rdNext;
      end else begin
        shReg <= {shReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  // storage array, erased state is all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (strobe.progCommit) begin
      case (strobe.kind)
        PK_WORD:  mem[cmdAddr] <= dataReg;
        PK_CLEAR: mem[cmdAddr] <= '1;
        PK_FILL:  for (int i = 0; i < WORDS; i++) mem[i] <= dataReg;
        default:  for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      endcase
    end
  end

  a_r2_dummy_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdLoad |=> (outBit == 1'b0));

  a_r3_addr_rollover: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdShift && strobe.rdWordEnd && (rdAddr == '1)) |=> (rdAddr == '0));

endmodule

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
  import seeprom_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              serClk,
  input  logic              serIn,
  input  logic              progEn,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              statusOn,
  output logic              serOutEn
);

  localparam int CMD_BITS = ADDR_W + 2;
  localparam int MAX_BITS = (CMD_BITS > DATA_W) ? CMD_BITS : DATA_W;
  localparam int CNT_W    = $clog2(MAX_BITS) + 1;
  localparam int PCNT_W   = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_EXEC, S_DATA, S_READ, S_HOLD, S_PROG
  } state_e;

  state_e           state;
  logic [CNT_W-1:0] bitCnt;
  logic [PCNT_W-1:0] progCnt;
  logic             skPrev;
  logic             skRise;
  logic             unlocked;
  logic             armed;
  progKind_e        kindReg;
  logic [1:0]       extCode;

  assign skRise  = serClk & ~skPrev;
  assign extCode = cmdAddr[ADDR_W-1 -: 2];
  assign busy    = (state == S_PROG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) skPrev <= 1'b0;
    else       skPrev <= serClk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      progCnt  <= '0;
      unlocked <= 1'b0;
      armed    <= 1'b0;
      kindReg  <= PK_WORD;
      statusOn <= 1'b0;
    end else if (state == S_PROG) begin
      if (progCnt == PCNT_W'(PROG_CYCLES - 1)) begin
        state   <= S_IDLE;
        progCnt <= '0;
      end else begin
        progCnt <= progCnt + 1'b1;
      end
    end else if (!chipSel) begin
      if (state == S_HOLD && armed) begin
        state    <= S_PROG;
        progCnt  <= '0;
        statusOn <= 1'b1;
      end else begin
        state <= S_IDLE;
      end
      armed <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (skRise && serIn) begin
          statusOn <= 1'b0;
          bitCnt   <= '0;
          state    <= S_CMD;
        end
        S_CMD: if (skRise) begin
          if (bitCnt == CNT_W'(CMD_BITS - 1)) state <= S_EXEC;
          else bitCnt <= bitCnt + 1'b1;
        end
        S_EXEC: begin
          bitCnt <= '0;
          case (cmdOp)
            OP_READ:  state <= S_READ;
            OP_WRITE: begin kindReg <= PK_WORD; state <= S_DATA; end
            OP_CLEAR: begin
              kindReg <= PK_CLEAR;
              armed   <= unlocked & progEn;
              state   <= S_HOLD;
            end
            default: begin
              case (extCode)
                EXT_UNLOCK: begin unlocked <= 1'b1; state <= S_HOLD; end
                EXT_LOCK:   begin unlocked <= 1'b0; state <= S_HOLD; end
                EXT_WIPE: begin
                  kindReg <= PK_WIPE;
                  armed   <= unlocked & progEn;
                  state   <= S_HOLD;
                end
                default: begin kindReg <= PK_FILL; state <= S_DATA; end
              endcase
            end
          endcase
        end
        S_DATA: if (skRise) begin
          if (bitCnt == CNT_W'(DATA_W - 1)) begin
            armed <= unlocked & progEn;
            state <= S_HOLD;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        S_READ: if (skRise) begin
          bitCnt <= (bitCnt == CNT_W'(DATA_W - 1)) ? '0 : bitCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.cmdShift   = chipSel && skRise && (state == S_CMD);
    strobe.dataShift  = chipSel && skRise && (state == S_DATA);
    strobe.rdLoad     = chipSel && (state == S_EXEC) && (cmdOp == OP_READ);
    strobe.rdShift    = chipSel && skRise && (state == S_READ);
    strobe.rdWordEnd  = (bitCnt == CNT_W'(DATA_W - 1));
    strobe.progCommit = busy && (progCnt == PCNT_W'(PROG_CYCLES - 1));
    strobe.kind       = kindReg;
  end

  assign serOutEn = chipSel && (statusOn || state == S_READ);

  a_r8_start_on_deselect: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !chipSel);

  a_r6_prog_needs_unlock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> unlocked);

  a_r9_commit_ends_cycle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strobe.progCommit));

  a_r11_no_decode_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.cmdShift && !strobe.dataShift);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdLoad |=> (serOutEn || !chipSel));

endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom
  import seeprom_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic serClk,
  input  logic serIn,
  input  logic progEn,
  output logic serOut,
  output logic serOutEn
);

  dpStrobe_t         strobe;
  logic [1:0]        cmdOp;
  logic [ADDR_W-1:0] cmdAddr;
  logic              outBit;
  logic              busy;
  logic              statusOn;

  seeprom_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk),
    .serIn(serIn), .progEn(progEn), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .strobe(strobe), .busy(busy), .statusOn(statusOn), .serOutEn(serOutEn)
  );

  seeprom_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .strobe(strobe),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .outBit(outBit)
  );

  assign serOut = statusOn ? ~busy : outBit;

  a_r10_release_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |-> !serOutEn);

endmodule

// File: tb/tb_serial_eeprom.sv
module tb_serial_eeprom;

  localparam int AW    = 3;
  localparam int DW    = 16;
  localparam int PROG  = 20;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0, serClk = 1'b0, serIn = 1'b0, progEn = 1'b0;
  logic serOut, serOutEn;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] model [WORDS];

  always #2.5 clk = ~clk;

  serial_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk),
    .serIn(serIn), .progEn(progEn), .serOut(serOut), .serOutEn(serOutEn)
  );

  // address / data pairs for the table-driven write and read-back pass
  localparam logic [AW+DW-1:0] VEC [4] = '{
    {3'd0, 16'h1234}, {3'd7, 16'hA5C3}, {3'd3, 16'h0F0F}, {3'd5, 16'h8001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clkBit(input logic b);
    serIn = b; tick(2);
    serClk = 1'b1; tick(3);
    serClk = 1'b0; tick(2);
  endtask

  task automatic rdBit(output logic b);
    serClk = 1'b1; tick(3);
    b = serOut;
    serClk = 1'b0; tick(2);
  endtask

  task automatic sel();   chipSel = 1'b1; tick(2); endtask
  task automatic desel(); chipSel = 1'b0; serIn = 1'b0; tick(2); endtask

  task automatic sendCmd(input logic [1:0] op, input logic [AW-1:0] a);
    clkBit(1'b1);
    clkBit(op[1]); clkBit(op[0]);
    for (int i = AW - 1; i >= 0; i--) clkBit(a[i]);
    tick(2);
  endtask

  task automatic sendData(input logic [DW-1:0] d);
    for (int i = DW - 1; i >= 0; i--) clkBit(d[i]);
  endtask

  task automatic readWord(output logic [DW-1:0] w);
    logic b;
    for (int i = DW - 1; i >= 0; i--) begin rdBit(b); w[i] = b; end
  endtask

  task automatic readCheck(input string req, input logic [AW-1:0] a);
    logic [DW-1:0] w;
    sel(); sendCmd(2'b10, a);
    chk({req, " dummy"}, {serOutEn, serOut}, 2'b10);
    readWord(w);
    chk(req, w, model[a]);
    desel();
  endtask

  task automatic ext(input logic [1:0] code);
    sel(); sendCmd(2'b00, {code, {(AW-2){1'b0}}});
    desel();
  endtask

  task automatic progWait(); desel(); tick(PROG + 8); endtask

  task automatic writeWord(input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel(); sendCmd(2'b01, a); sendData(d); progWait();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    for (int i = 0; i < WORDS; i++) model[i] = '1;
    tick(4); rstN = 1'b1; tick(4);

    // R10 / R12: reset state
    chk("R10 idle release", serOutEn, 1'b0);
    sel();
    chk("R10 selected idle", serOutEn, 1'b0);
    desel();
    readCheck("R12 erased after reset", 3'd2);

    // R6: locked after reset, write ignored
    progEn = 1'b1;
    writeWord(3'd4, 16'h1111);
    readCheck("R6 locked write ignored", 3'd4);

    // R6: unlock works with progEn low
    progEn = 1'b0; ext(2'b11); progEn = 1'b1;

    // R4: table-driven write and read-back
    for (int k = 0; k < 4; k++) begin
      writeWord(VEC[k][AW+DW-1:DW], VEC[k][DW-1:0]);
      model[VEC[k][AW+DW-1:DW]] = VEC[k][DW-1:0];
      readCheck("R4 write readback", VEC[k][AW+DW-1:DW]);
    end
    // R4: overwrite without clear
    writeWord(3'd3, 16'hF0F1); model[3] = 16'hF0F1;
    readCheck("R4 overwrite", 3'd3);

    // R1 / R3: leading zeros, then sequential read across rollover
    sel();
    clkBit(1'b0); clkBit(1'b0);
    sendCmd(2'b10, 3'd6);
    chk("R1 R2 dummy after address", {serOutEn, serOut}, 2'b10);
    for (int k = 0; k < 4; k++) begin
      readWord(w);
      chk("R3 sequential word", w, model[(6 + k) % WORDS]);
    end
    desel();
    chk("R10 released after read", serOutEn, 1'b0);

    // R5: single word clear
    sel(); sendCmd(2'b11, 3'd3); progWait(); model[3] = '1;
    readCheck("R5 word clear", 3'd3);

    // R7: program ignored without progEn
    progEn = 1'b0;
    writeWord(3'd0, 16'hDEAD);
    readCheck("R7 progEn low ignored", 3'd0);
    progEn = 1'b1;

    // R8: early deselect drops the command
    sel(); sendCmd(2'b01, 3'd7);
    for (int i = 0; i < 8; i++) clkBit(1'b1);
    desel(); sel();
    chk("R8 no busy after abort", serOutEn, 1'b0);
    desel();
    readCheck("R8 abort keeps data", 3'd7);

    // R9 / R11: busy polling and start bit ignored while busy
    sel(); sendCmd(2'b01, 3'd1); sendData(16'h00FF);
    desel(); sel();
    chk("R9 busy status", {serOutEn, serOut}, 2'b10);
    clkBit(1'b1);
    tick(PROG);
    chk("R9 R11 ready status kept", {serOutEn, serOut}, 2'b11);
    desel();
    chk("R10 status released", serOutEn, 1'b0);
    model[1] = 16'h00FF;
    readCheck("R9 write after poll", 3'd1);

    // R5: array fill and array clear
    sel(); sendCmd(2'b00, {2'b01, {(AW-2){1'b0}}}); sendData(16'h5A5A); progWait();
    for (int i = 0; i < WORDS; i++) model[i] = 16'h5A5A;
    readCheck("R5 fill low", 3'd0);
    readCheck("R5 fill high", 3'd7);
    ext(2'b10); tick(PROG + 8);
    for (int i = 0; i < WORDS; i++) model[i] = '1;
    readCheck("R5 array clear", 3'd5);

    // R6: lock then write ignored
    ext(2'b00);
    writeWord(3'd2, 16'h2222);
    readCheck("R6 relocked write ignored", 3'd2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule